// File: doc/BRIEF.md
# Round-Trip Clock Offset Calibrator

This block measures the cable delay between a central timing station and a remote board, and how far the remote board's clock is from the central one. The central side sends a one-cycle pulse and stamps its own time when the pulse leaves (t1). The remote side stamps the arrival in its own time base. It then holds the pulse for a programmed number of cycles and sends it back. The central side stamps the returning pulse (t2).

From t1, t2 and the known turnaround it derives:
- the one-way delay, as half of the round trip minus the turnaround;
- the remote time offset, as the remote arrival stamp minus the central time at which the pulse reached the remote board.

Both time bases arrive as free-running counters. All arithmetic is modulo the counter width, so an exchange may straddle a counter wrap. A return that does not come back within a programmable window ends the exchange with an error flag and leaves the previous results in place. The link pulse lines are ports, so the cable sits outside the block.

Top module: `rtt_offset_cal`

## Requirements
- R1: While reset is high and in the cycle after it, every output is zero.
- R2: A start request sampled while idle raises ctr_pulse_out for exactly one cycle P, the cycle after the request. t1 is center_time during cycle P, and busy is high from cycle P onward.
- R3: When rmt_pulse_in is high in cycle a while the remote side is idle, rmt_pulse_out is high for exactly cycle a+W, where W is wait_cycles and a value of 0 acts as 1. The arrival stamp is remote_time during cycle a, and further arrivals are ignored until the echo leaves.
- R4: t2 is center_time during the first cycle in which ctr_pulse_in is seen high while waiting for the return.
- R5: link_delay is ((t2 - t1 - W) mod 2^32) shifted right by one bit, and delay_odd is bit 0 of that difference.
- R6: remote_offset equals (arrival stamp - t1 - link_delay) mod 2^32.
- R7: After a return in cycle r, done is high for exactly cycle r+3. In that same cycle busy goes low and timeout_err reads 0.
- R8: If no return is seen in cycles P+1 through P+T (T = timeout_cycles, at least 1), done and timeout_err rise in cycle P+T+1 and the results stay unchanged. A return in exactly cycle P+T is accepted.
- R9: A start request sampled while busy is ignored: no pulse is sent and the running exchange is unaffected. A request in the cycle done is high is accepted.
- R10: Results are correct when t1, t2 or the remote stamps wrap past 2^32.
- R11: link_delay, delay_odd and remote_offset change only in a cycle where done is high. A late echo that arrives after a timeout changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst | input | 1 | Synchronous active-high reset |
| cal_start | input | 1 | Request a calibration exchange |
| wait_cycles | input | WAIT_W (16) | Remote turnaround in cycles (0 acts as 1) |
| timeout_cycles | input | TMO_W (16) | Return window in cycles after the sent pulse |
| center_time | input | TS_W (32) | Central free-running time counter |
| remote_time | input | TS_W (32) | Remote free-running time counter |
| ctr_pulse_out | output | 1 | Calibration pulse toward the remote side |
| ctr_pulse_in | input | 1 | Returned pulse arriving at the central side |
| rmt_pulse_in | input | 1 | Calibration pulse arriving at the remote side |
| rmt_pulse_out | output | 1 | Echo pulse leaving the remote side |
| busy | output | 1 | Exchange in progress |
| done | output | 1 | One-cycle end-of-exchange strobe |
| timeout_err | output | 1 | Last exchange ended without a return |
| link_delay | output | TS_W (32) | One-way delay in time counts |
| delay_odd | output | 1 | Round trip minus turnaround was odd |
| remote_offset | output | TS_W (32) | Remote time minus central time |

## Verification
Two events can land in the same cycle: the returning pulse and the last cycle of the return window. The bench provokes this by choosing cable delays and a turnaround whose sum equals timeout_cycles exactly, so the echo arrives in cycle P+T. It then expects a normal result with timeout_err low. A second run uses a window one cycle shorter; there the bench expects a timeout, followed by a late echo that must leave every output untouched. A start request issued in the very cycle done is high is also provoked, and a new pulse must follow in the next cycle.

// File: rtl/rtt_cal_pkg.sv
package rtt_cal_pkg;

  typedef enum logic [2:0] {
    C_IDLE = 3'd0,
    C_SEND = 3'd1,
    C_WAIT = 3'd2,
    C_DIFF = 3'd3,
    C_POST = 3'd4
  } ctr_state_e;

endpackage

// File: rtl/rtt_remote_echo.sv
module rtt_remote_echo #(
  parameter int TS_W   = 32,
  parameter int WAIT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pulse_in,
  input  logic [TS_W-1:0]   remote_time,
  input  logic [WAIT_W-1:0] wait_cycles,
  output logic              pulse_out,
  output logic [TS_W-1:0]   arr_ts
);

  localparam logic [WAIT_W-1:0] ONE = WAIT_W'(1);

  logic [WAIT_W-1:0] cnt_q;
  logic [WAIT_W-1:0] wait_eff;
  logic              pulse_q;
  logic [TS_W-1:0]   ts_q;

  // zero turnaround is raised to one cycle, the shortest echo possible
  assign wait_eff = (wait_cycles == '0) ? ONE : wait_cycles;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
      ts_q    <= '0;
    end else begin
      pulse_q <= 1'b0;
      if (cnt_q != '0) begin
        cnt_q <= cnt_q - ONE;
        if (cnt_q == ONE) pulse_q <= 1'b1;
      end else if (pulse_in) begin
        ts_q  <= remote_time;
        cnt_q <= wait_eff - ONE;
        if (wait_eff == ONE) pulse_q <= 1'b1;
      end
    end
  end

  assign pulse_out = pulse_q;
  assign arr_ts    = ts_q;

endmodule

// File: rtl/rtt_center_seq.sv
module rtt_center_seq
  import rtt_cal_pkg::*;
#(
  parameter int TS_W   = 32,
  parameter int WAIT_W = 16,
  parameter int TMO_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [WAIT_W-1:0] wait_cycles,
  input  logic [TMO_W-1:0]  tmo_cycles,
  input  logic [TS_W-1:0]   center_time,
  input  logic              pulse_in,
  output logic              pulse_out,
  output logic              busy,
  output logic              calc_go,
  output logic              tmo_hit,
  output logic [TS_W-1:0]   t1,
  output logic [TS_W-1:0]   t2,
  output logic [WAIT_W-1:0] wait_used
);

  localparam logic [WAIT_W-1:0] W_ONE = WAIT_W'(1);
  localparam logic [TMO_W-1:0]  T_ONE = TMO_W'(1);

  ctr_state_e        state_q;
  logic              pulse_q;
  logic [TS_W-1:0]   t1_q, t2_q;
  logic [WAIT_W-1:0] wait_q;
  logic [TMO_W-1:0]  tmo_q, elapsed_q;

  // the window closes at the edge ending cycle P+T; a return seen there wins
  assign tmo_hit = (state_q == C_WAIT) && !pulse_in && (elapsed_q >= tmo_q);
  assign calc_go = (state_q == C_DIFF);
  assign busy    = (state_q != C_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= C_IDLE;
      pulse_q   <= 1'b0;
      t1_q      <= '0;
      t2_q      <= '0;
      wait_q    <= '0;
      tmo_q     <= '0;
      elapsed_q <= '0;
    end else begin
      pulse_q <= 1'b0;
      unique case (state_q)
        C_IDLE: begin
          if (start) begin
            state_q <= C_SEND;
            pulse_q <= 1'b1;
            wait_q  <= (wait_cycles == '0) ? W_ONE : wait_cycles;
            tmo_q   <= tmo_cycles;
          end
        end
        C_SEND: begin
          t1_q      <= center_time;
          elapsed_q <= T_ONE;
          state_q   <= C_WAIT;
        end
        C_WAIT: begin
          if (pulse_in) begin
            t2_q    <= center_time;
            state_q <= C_DIFF;
          end else if (tmo_hit) begin
            state_q <= C_IDLE;
          end else begin
            elapsed_q <= elapsed_q + T_ONE;
          end
        end
        C_DIFF:  state_q <= C_POST;
        C_POST:  state_q <= C_IDLE;
        default: state_q <= C_IDLE;
      endcase
    end
  end

  assign pulse_out = pulse_q;
  assign t1        = t1_q;
  assign t2        = t2_q;
  assign wait_used = wait_q;

endmodule

// File: rtl/rtt_result_calc.sv
module rtt_result_calc #(
  parameter int TS_W   = 32,
  parameter int WAIT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              calc_go,
  input  logic              tmo_hit,
  input  logic [TS_W-1:0]   t1,
  input  logic [TS_W-1:0]   t2,
  input  logic [WAIT_W-1:0] wait_used,
  input  logic [TS_W-1:0]   arr_ts,
  output logic [TS_W-1:0]   link_delay,
  output logic              delay_odd,
  output logic [TS_W-1:0]   remote_offset,
  output logic              done,
  output logic              timeout_err
);

  logic [TS_W-1:0] wait_ext;
  logic [TS_W-1:0] diff_q;
  logic [TS_W-1:0] half;
  logic            v_q;
  logic [TS_W-1:0] dly_q, off_q;
  logic            odd_q, done_q, err_q;

  assign wait_ext = {{(TS_W-WAIT_W){1'b0}}, wait_used};
  assign half     = {1'b0, diff_q[TS_W-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      diff_q <= '0;
      v_q    <= 1'b0;
      dly_q  <= '0;
      off_q  <= '0;
      odd_q  <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      v_q    <= calc_go;
      if (calc_go) diff_q <= t2 - t1 - wait_ext;
      if (v_q) begin
        dly_q  <= half;
        odd_q  <= diff_q[0];
        off_q  <= arr_ts - t1 - half;
        done_q <= 1'b1;
        err_q  <= 1'b0;
      end else if (tmo_hit) begin
        done_q <= 1'b1;
        err_q  <= 1'b1;
      end
    end
  end

  assign link_delay    = dly_q;
  assign delay_odd     = odd_q;
  assign remote_offset = off_q;
  assign done          = done_q;
  assign timeout_err   = err_q;

endmodule

// File: rtl/rtt_offset_cal.sv
module rtt_offset_cal #(
  parameter int TS_W   = 32,
  parameter int WAIT_W = 16,
  parameter int TMO_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cal_start,
  input  logic [WAIT_W-1:0] wait_cycles,
  input  logic [TMO_W-1:0]  timeout_cycles,
  input  logic [TS_W-1:0]   center_time,
  input  logic [TS_W-1:0]   remote_time,
  output logic              ctr_pulse_out,
  input  logic              ctr_pulse_in,
  input  logic              rmt_pulse_in,
  output logic              rmt_pulse_out,
  output logic              busy,
  output logic              done,
  output logic              timeout_err,
  output logic [TS_W-1:0]   link_delay,
  output logic              delay_odd,
  output logic [TS_W-1:0]   remote_offset
);

  logic              calc_go, tmo_hit;
  logic [TS_W-1:0]   t1, t2, arr_ts;
  logic [WAIT_W-1:0] wait_used;

  rtt_remote_echo #(.TS_W(TS_W), .WAIT_W(WAIT_W)) u_remote (
    .clk         (clk),
    .rst         (rst),
    .pulse_in    (rmt_pulse_in),
    .remote_time (remote_time),
    .wait_cycles (wait_cycles),
    .pulse_out   (rmt_pulse_out),
    .arr_ts      (arr_ts)
  );

  rtt_center_seq #(.TS_W(TS_W), .WAIT_W(WAIT_W), .TMO_W(TMO_W)) u_center (
    .clk         (clk),
    .rst         (rst),
    .start       (cal_start),
    .wait_cycles (wait_cycles),
    .tmo_cycles  (timeout_cycles),
    .center_time (center_time),
    .pulse_in    (ctr_pulse_in),
    .pulse_out   (ctr_pulse_out),
    .busy        (busy),
    .calc_go     (calc_go),
    .tmo_hit     (tmo_hit),
    .t1          (t1),
    .t2          (t2),
    .wait_used   (wait_used)
  );

  rtt_result_calc #(.TS_W(TS_W), .WAIT_W(WAIT_W)) u_calc (
    .clk           (clk),
    .rst           (rst),
    .calc_go       (calc_go),
    .tmo_hit       (tmo_hit),
    .t1            (t1),
    .t2            (t2),
    .wait_used     (wait_used),
    .arr_ts        (arr_ts),
    .link_delay    (link_delay),
    .delay_odd     (delay_odd),
    .remote_offset (remote_offset),
    .done          (done),
    .timeout_err   (timeout_err)
  );

endmodule

// File: rtl/rtt_offset_cal_chk.sv
module rtt_offset_cal_chk #(
  parameter int TS_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            cal_start,
  input logic            ctr_pulse_out,
  input logic            busy,
  input logic            done,
  input logic            timeout_err,
  input logic [TS_W-1:0] link_delay,
  input logic            delay_odd,
  input logic [TS_W-1:0] remote_offset
);

  // R2
  pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
    ctr_pulse_out |=> !ctr_pulse_out);

  // R9
  start_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ctr_pulse_out) |-> ($past(cal_start) && !$past(busy)));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7
  busy_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  // R11
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(link_delay) && $stable(remote_offset) && $stable(delay_odd)));

  // R8
  tmo_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (done && timeout_err) |-> ($stable(link_delay) && $stable(remote_offset)));

endmodule

bind rtt_offset_cal rtt_offset_cal_chk #(.TS_W(TS_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .cal_start     (cal_start),
  .ctr_pulse_out (ctr_pulse_out),
  .busy          (busy),
  .done          (done),
  .timeout_err   (timeout_err),
  .link_delay    (link_delay),
  .delay_odd     (delay_odd),
  .remote_offset (remote_offset)
);

// File: tb/rtt_offset_cal_tb.sv
module rtt_offset_cal_tb;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'hFFFF_FF88;  // center time wraps at cycle 120
  localparam logic [31:0] KOFF = 32'h8000_0123;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cal_start = 1'b0;
  logic [15:0] wait_cycles = '0;
  logic [15:0] timeout_cycles = '0;
  logic [31:0] center_time = '0;
  logic [31:0] remote_time = '0;
  logic        ctr_pulse_out, ctr_pulse_in, rmt_pulse_in, rmt_pulse_out;
  logic        busy, done, timeout_err, delay_odd;
  logic [31:0] link_delay, remote_offset;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtt_offset_cal u_dut (
    .clk(clk), .rst(rst), .cal_start(cal_start), .wait_cycles(wait_cycles),
    .timeout_cycles(timeout_cycles), .center_time(center_time),
    .remote_time(remote_time), .ctr_pulse_out(ctr_pulse_out),
    .ctr_pulse_in(ctr_pulse_in), .rmt_pulse_in(rmt_pulse_in),
    .rmt_pulse_out(rmt_pulse_out), .busy(busy), .done(done),
    .timeout_err(timeout_err), .link_delay(link_delay),
    .delay_odd(delay_odd), .remote_offset(remote_offset)
  );

  typedef struct {
    logic [31:0] dly;
    logic        odd;
    logic [31:0] off;
    logic        err;
    bit          upd;
  } res_t;

  int nchk = 0, nfail = 0, cyc = 0, last_done = 0, pulse_cnt = 0;
  int ld1 = 0, ld2 = 0;
  bit cut = 0, finished = 0;
  bit fwd_log[int], ret_log[int];
  bit pulse_at[int], rpulse_at[int], busy_at[int], done_at[int];
  res_t res_at[int];
  logic [31:0] e_dly = '0, e_off = '0;
  logic        e_odd = 1'b0, e_err = 1'b0;

  initial begin
    ctr_pulse_in = 1'b0;
    rmt_pulse_in = 1'b0;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // time bases, cable model and per-cycle comparison against the model
  always @(negedge clk) begin
    center_time = BASE + 32'(cyc);
    remote_time = BASE + 32'(cyc) + KOFF;
    fwd_log[cyc] = ctr_pulse_out;
    ret_log[cyc] = rmt_pulse_out;
    rmt_pulse_in = fwd_log.exists(cyc - ld1) ? fwd_log[cyc - ld1] : 1'b0;
    ctr_pulse_in = !cut && (ret_log.exists(cyc - ld2) ? ret_log[cyc - ld2] : 1'b0);
    if (ctr_pulse_out === 1'b1) pulse_cnt++;
    if (!rst && !finished) begin
      if (res_at.exists(cyc)) begin
        e_err = res_at[cyc].err;
        if (res_at[cyc].upd) begin
          e_dly = res_at[cyc].dly;
          e_odd = res_at[cyc].odd;
          e_off = res_at[cyc].off;
        end
      end
      chk("R2 ctr_pulse_out", 64'(ctr_pulse_out), 64'(pulse_at.exists(cyc)));
      chk("R3 rmt_pulse_out", 64'(rmt_pulse_out), 64'(rpulse_at.exists(cyc)));
      chk("R9 busy", 64'(busy), 64'(busy_at.exists(cyc)));
      chk("R7 done", 64'(done), 64'(done_at.exists(cyc)));
      chk("R5 link_delay", 64'(link_delay), 64'(e_dly));
      chk("R5 delay_odd", 64'(delay_odd), 64'(e_odd));
      chk("R6 remote_offset", 64'(remote_offset), 64'(e_off));
      chk("R8 timeout_err", 64'(timeout_err), 64'(e_err));
    end
  end

  // drive a start in the current cycle and schedule the expected outcome
  task automatic do_cal(input int d1, input int d2, input int w, input int tmo, input bit c);
    int s, p, a, we, ro, r, dn;
    res_t rs;
    logic [31:0] t1, t2, arr, diff;
    s = cyc;
    ld1 = d1; ld2 = d2; cut = c;
    wait_cycles = 16'(w);
    timeout_cycles = 16'(tmo);
    cal_start = 1'b1;
    if (!busy_at.exists(s)) begin
      p  = s + 1;
      a  = p + d1;
      we = (w == 0) ? 1 : w;
      ro = a + we;
      r  = ro + d2;
      pulse_at[p] = 1;
      rpulse_at[ro] = 1;
      if (!c && (r - p) <= tmo) begin
        dn = r + 3;
        t1 = BASE + 32'(p);
        t2 = BASE + 32'(r);
        arr = BASE + 32'(a) + KOFF;
        diff = t2 - t1 - 32'(we);
        rs.dly = diff >> 1;
        rs.odd = diff[0];
        rs.off = arr - (t1 + rs.dly);
        rs.err = 1'b0;
        rs.upd = 1;
      end else begin
        dn = p + tmo + 1;
        rs.dly = '0; rs.odd = 1'b0; rs.off = '0;
        rs.err = 1'b1;
        rs.upd = 0;
      end
      for (int k = p; k < dn; k++) busy_at[k] = 1;
      done_at[dn] = 1;
      res_at[dn] = rs;
      last_done = dn;
    end
    @(posedge clk); #1;
    cal_start = 1'b0;
  endtask

  task automatic wait_cycle_n(input int n);
    while (cyc < n) begin @(posedge clk); #1; end
  endtask

  initial begin
    int pc;
    logic [31:0] keep_d, keep_o;
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", 64'(busy), 0);
    chk("R1 done", 64'(done), 0);
    chk("R1 link_delay", 64'(link_delay), 0);
    chk("R1 remote_offset", 64'(remote_offset), 0);
    chk("R1 pulses", 64'({ctr_pulse_out, rmt_pulse_out, timeout_err, delay_odd}), 0);
    @(posedge clk); #1;

    // symmetric cable: one-way delay equals the cable delay (R4)
    do_cal(4, 4, 10, 100, 0);
    wait_cycle_n(last_done + 1);
    chk("R4 symmetric delay", 64'(link_delay), 4);
    chk("R4 symmetric offset", 64'(remote_offset), 64'(KOFF));

    // exchange straddling the counter wrap at cycle 120 (R10)
    wait_cycle_n(110);
    do_cal(6, 6, 8, 100, 0);
    wait_cycle_n(last_done + 1);
    chk("R10 wrap delay", 64'(link_delay), 6);
    chk("R10 wrap offset", 64'(remote_offset), 64'(KOFF));

    // asymmetric cable with odd remainder (R5, R6)
    do_cal(2, 5, 7, 100, 0);
    wait_cycle_n(last_done + 1);
    chk("R5 odd flag", 64'(delay_odd), 1);
    chk("R5 halved delay", 64'(link_delay), 3);
    chk("R6 skewed offset", 64'(remote_offset), 64'(KOFF - 32'd1));

    // zero turnaround acts as one cycle (R3)
    do_cal(3, 3, 0, 100, 0);
    wait_cycle_n(last_done + 1);
    chk("R3 zero wait delay", 64'(link_delay), 3);

    // start in the done cycle is accepted, start while busy is not (R9)
    do_cal(1, 1, 5, 100, 0);
    wait_cycle_n(last_done);
    pc = pulse_cnt;
    do_cal(2, 2, 5, 100, 0);
    repeat (3) begin @(posedge clk); #1; end
    cal_start = 1'b1;
    @(posedge clk); #1;
    cal_start = 1'b0;
    wait_cycle_n(last_done + 1);
    chk("R9 one pulse per exchange", 64'(pulse_cnt - pc), 1);
    chk("R9 running exchange kept", 64'(link_delay), 2);

    // broken return path: timeout, results kept (R8, R11)
    keep_d = link_delay; keep_o = remote_offset;
    do_cal(2, 2, 4, 20, 1);
    wait_cycle_n(last_done);
    @(negedge clk);
    chk("R8 timeout flagged", 64'({done, timeout_err}), 64'(2'b11));
    chk("R11 delay kept on timeout", 64'(link_delay), 64'(keep_d));
    wait_cycle_n(last_done + 10);

    // return in the very last cycle of the window is accepted (R8)
    do_cal(3, 3, 4, 10, 0);
    wait_cycle_n(last_done + 1);
    chk("R8 boundary accepted", 64'(timeout_err), 0);
    chk("R8 boundary delay", 64'(link_delay), 3);

    // window one cycle short: timeout, then the late echo changes nothing (R11)
    keep_d = link_delay; keep_o = remote_offset;
    do_cal(3, 3, 4, 9, 0);
    wait_cycle_n(last_done + 12);
    chk("R8 short window", 64'(timeout_err), 1);
    chk("R11 late echo delay", 64'(link_delay), 64'(keep_d));
    chk("R11 late echo offset", 64'(remote_offset), 64'(keep_o));

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

endmodule